// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

This block is the transmit half of a serial audio port that acts as clock master. It divides the system clock down to a bit clock and drives a frame sync. It also shifts audio words out on a single data line. A frame holds one or two slots, and every slot carries one word of the programmed width. Words come from a small internal FIFO, which is filled through a valid/ready interface.

Several static controls define the line format: sync early or aligned, sync lasting one bit or a whole word, sync polarity, bit clock polarity, word width, one or two slots, MSB-first or LSB-first order, and a per-slot mask. These controls cover I2S, left-justified and both short-sync DSP formats. They must be held steady while `active` is high. Setting `tx_en` starts framing. Clearing it stops the output only after the current frame is complete.

Top module: `sat_tx`

## Requirements
- R1: After reset, `active` and `sdata` are 0, `in_ready` is 1, `bclk` rests at `cfg_bclk_inv` and `fsync` rests at `cfg_sync_actlow` (the sync's inactive level).
- R2: While active, one bit period lasts 2*(`cfg_div`+1) system clocks. Data and sync change only on the driving edge of the bit clock (the falling edge, or the rising edge when `cfg_bclk_inv`=1) and stay stable across the sampling edge. `cfg_bclk_inv`=1 inverts `bclk`.
- R3: `cfg_lsb_first`=0 sends word bit `cfg_word_w`-1 first. `cfg_lsb_first`=1 sends bit 0 first.
- R4: A frame holds 1 slot when `cfg_two_slots`=0 and 2 slots when it is 1. Each slot is `cfg_word_w` bits long. Slots and frames follow each other with no gap.
- R5: With `cfg_early`=0, the sync starts on the first bit of slot 0. It lasts `cfg_word_w` bits when `cfg_word_sync`=1 and one bit when it is 0.
- R6: With `cfg_early`=1, the sync starts one bit earlier, on the last bit of the previous frame. Framing then begins with one lead-in bit that carries data 0 and sync asserted. For a word-length sync, the sync covers that early bit and the first `cfg_word_w`-1 bits of slot 0.
- R7: `cfg_sync_actlow`=1 makes `fsync` active low. Otherwise it is active high.
- R8: Setting bit s of `cfg_slot_mask` masks slot s. A masked slot sends zeros and takes no FIFO word. In a one-slot frame, bit 1 has no effect.
- R9: If the FIFO is empty when an unmasked slot begins, that slot sends zeros and `underrun` pulses high for one system clock.
- R10: After `tx_en` is cleared, `active` stays high and bits keep flowing until the last bit of the current frame has been sent. Then the outputs return to their idle levels.
- R11: The FIFO holds `FIFO_DEPTH` words in order. `in_ready` is low only when the FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Enable; cleared value takes effect at frame end |
| cfg_early | input | 1 | Sync one bit before the first data bit |
| cfg_word_sync | input | 1 | 1: sync lasts one word, 0: one bit |
| cfg_sync_actlow | input | 1 | Sync active low |
| cfg_bclk_inv | input | 1 | Invert bit clock |
| cfg_word_w | input | $clog2(MAX_W+1) | Word width in bits, 2..MAX_W |
| cfg_two_slots | input | 1 | Two slots per frame |
| cfg_lsb_first | input | 1 | Bit order |
| cfg_slot_mask | input | 2 | Per-slot mask, 1 = masked |
| cfg_div | input | DIV_W | Bit clock half period minus one, in system clocks |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | FIFO can accept |
| in_data | input | MAX_W | Audio word, right-aligned |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| active | output | 1 | Framing in progress |
| underrun | output | 1 | One-clock pulse on FIFO starvation |

## Verification
On every cycle, the bound assertions check that data moves only on the driving edge, that idle outputs sit at their rest levels, that an underrun is a one-clock pulse occurring only while framing, and that `active` never drops unless `tx_en` was already low. Bit order, sync placement and width, slot masking, the lead-in bit, the divider period and the exact frame-end stop can only be shown by the bench's scenarios. The bench recovers the serial stream at the bit clock's sampling edge and compares it against frames built from the requirements.

// File: rtl/sat_pkg.sv
package sat_pkg;

   typedef enum logic [1:0] {
      SAT_IDLE = 2'd0,
      SAT_LEAD = 2'd1,
      SAT_RUN  = 2'd2
   } sat_state_e;

   // Logical (active-true) sync level for the bit position about to be driven.
   function automatic logic sat_sync_at(
      input logic word_sync,
      input logic early,
      input logic in_slot0,
      input logic first_bit,
      input logic below_last,
      input logic last_pos
   );
      if (word_sync)
         return early ? ((in_slot0 && below_last) || last_pos) : in_slot0;
      else
         return early ? last_pos : (in_slot0 && first_bit);
   endfunction

endpackage

// File: rtl/sat_clkgen.sv
module sat_clkgen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             bclk_raw,
   output logic             fall_evt
);

   logic [DIV_W-1:0] half_q;
   logic             raw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= '0;
         raw_q  <= 1'b0;
      end else if (!run) begin
         half_q <= '0;
         raw_q  <= 1'b0;
      end else if (half_q == div) begin
         half_q <= '0;
         raw_q  <= ~raw_q;
      end else begin
         half_q <= half_q + 1'b1;
      end
   end

   // Driving edge: the raw clock is about to fall.
   assign fall_evt = run && raw_q && (half_q == div);
   assign bclk_raw = raw_q;

endmodule

// File: rtl/sat_fifo.sv
module sat_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   output logic [W-1:0] out_data,
   input  logic         pop
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = (DEPTH > 1) && ((DEPTH & (DEPTH - 1)) == 0);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_q, rd_q, wr_nx, rd_nx;
   logic [CW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign in_ready  = (cnt_q != DEPTH[CW-1:0]);
   assign out_valid = (cnt_q != '0);
   assign out_data  = mem[rd_q];
   assign do_push   = in_valid && in_ready;
   assign do_pop    = pop && out_valid;

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nx = wr_q + 1'b1;
         assign rd_nx = rd_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nx = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
         assign rd_nx = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_q <= wr_nx;
         if (do_pop)  rd_q <= rd_nx;
         if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
         else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_q] <= in_data;
   end

endmodule

// File: rtl/sat_seq.sv
module sat_seq
   import sat_pkg::*;
#(
   parameter int MAX_W = 32,
   parameter int WW    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             fall_evt,
   input  logic             cfg_early,
   input  logic             cfg_word_sync,
   input  logic [WW-1:0]    cfg_word_w,
   input  logic             cfg_two_slots,
   input  logic             cfg_lsb_first,
   input  logic [1:0]       cfg_slot_mask,
   input  logic             fifo_valid,
   input  logic [MAX_W-1:0] fifo_data,
   output logic             fifo_pop,
   output logic             active,
   output logic             sdata_q,
   output logic             sync_q,
   output logic             underrun_q
);

   localparam int IW = (MAX_W > 1) ? $clog2(MAX_W) : 1;

   sat_state_e       st_q, st_d;
   logic [WW-1:0]    bit_q, bit_d, wm1, sel;
   logic             slot_q, slot_d;
   logic [MAX_W-1:0] word_q, word_d;
   logic             evt, last_bit, last_slot, last_pos;
   logic             slot_live, load, starve, bit_val, sync_d;

   assign wm1       = cfg_word_w - {{(WW-1){1'b0}}, 1'b1};
   assign evt       = ((st_q == SAT_IDLE) && en) || fall_evt;
   assign last_bit  = (bit_q == wm1);
   assign last_slot = (slot_q == cfg_two_slots);

   // Position that the next drive event presents.
   always_comb begin
      st_d   = st_q;
      bit_d  = bit_q;
      slot_d = slot_q;
      unique case (st_q)
         SAT_IDLE: begin
            if (en) begin
               bit_d  = '0;
               slot_d = 1'b0;
               st_d   = cfg_early ? SAT_LEAD : SAT_RUN;
            end
         end
         SAT_LEAD: begin
            bit_d  = '0;
            slot_d = 1'b0;
            st_d   = SAT_RUN;
         end
         SAT_RUN: begin
            if (last_bit && last_slot) begin
               bit_d  = '0;
               slot_d = 1'b0;
               st_d   = en ? SAT_RUN : SAT_IDLE;
            end else if (last_bit) begin
               bit_d  = '0;
               slot_d = 1'b1;
            end else begin
               bit_d  = bit_q + 1'b1;
            end
         end
         default: st_d = SAT_IDLE;
      endcase
   end

   // Last bit of a frame that another frame will follow (early sync slot).
   assign last_pos = (st_d == SAT_LEAD) ||
                     ((st_d == SAT_RUN) && (bit_d == wm1) &&
                      (slot_d == cfg_two_slots) && en);

   assign sync_d = (st_d != SAT_IDLE) &&
                   sat_sync_at(cfg_word_sync, cfg_early, !slot_d,
                               (bit_d == '0), (bit_d < wm1), last_pos);

   assign slot_live = (st_d == SAT_RUN) && (!slot_d || cfg_two_slots) &&
                      !cfg_slot_mask[slot_d];
   assign load      = (st_d == SAT_RUN) && (bit_d == '0);
   assign starve    = load && slot_live && !fifo_valid;
   assign fifo_pop  = evt && load && slot_live && fifo_valid;

   always_comb begin
      if (!load)
         word_d = word_q;
      else if (slot_live && fifo_valid)
         word_d = fifo_data;
      else
         word_d = '0;
   end

   assign sel     = cfg_lsb_first ? bit_d : (wm1 - bit_d);
   assign bit_val = (st_d == SAT_RUN) && word_d[sel[IW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= SAT_IDLE;
         bit_q      <= '0;
         slot_q     <= 1'b0;
         word_q     <= '0;
         sdata_q    <= 1'b0;
         sync_q     <= 1'b0;
         underrun_q <= 1'b0;
      end else begin
         underrun_q <= evt && starve;
         if (evt) begin
            st_q    <= st_d;
            bit_q   <= bit_d;
            slot_q  <= slot_d;
            word_q  <= word_d;
            sdata_q <= bit_val;
            sync_q  <= sync_d;
         end
      end
   end

   assign active = (st_q != SAT_IDLE);

endmodule

// File: rtl/sat_tx.sv
module sat_tx
   import sat_pkg::*;
#(
   parameter int MAX_W      = 32,
   parameter int FIFO_DEPTH = 4,
   parameter int DIV_W      = 8,
   localparam int WW        = $clog2(MAX_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_en,
   input  logic             cfg_early,
   input  logic             cfg_word_sync,
   input  logic             cfg_sync_actlow,
   input  logic             cfg_bclk_inv,
   input  logic [WW-1:0]    cfg_word_w,
   input  logic             cfg_two_slots,
   input  logic             cfg_lsb_first,
   input  logic [1:0]       cfg_slot_mask,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [MAX_W-1:0] in_data,
   output logic             bclk,
   output logic             fsync,
   output logic             sdata,
   output logic             active,
   output logic             underrun
);

   generate
      if (MAX_W < 2) begin : g_bad_width
         $error("sat_tx: MAX_W must be at least 2");
      end
      if (FIFO_DEPTH < 1) begin : g_bad_depth
         $error("sat_tx: FIFO_DEPTH must be at least 1");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("sat_tx: DIV_W must be at least 1");
      end
   endgenerate

   logic             f_valid, f_pop, raw, fall_evt, sync_l, sd_l;
   logic [MAX_W-1:0] f_data;

   sat_fifo #(.W(MAX_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_data  (in_data),
      .out_valid(f_valid),
      .out_data (f_data),
      .pop      (f_pop)
   );

   sat_clkgen #(.DIV_W(DIV_W)) u_clk (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (active),
      .div     (cfg_div),
      .bclk_raw(raw),
      .fall_evt(fall_evt)
   );

   sat_seq #(.MAX_W(MAX_W), .WW(WW)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (tx_en),
      .fall_evt     (fall_evt),
      .cfg_early    (cfg_early),
      .cfg_word_sync(cfg_word_sync),
      .cfg_word_w   (cfg_word_w),
      .cfg_two_slots(cfg_two_slots),
      .cfg_lsb_first(cfg_lsb_first),
      .cfg_slot_mask(cfg_slot_mask),
      .fifo_valid   (f_valid),
      .fifo_data    (f_data),
      .fifo_pop     (f_pop),
      .active       (active),
      .sdata_q      (sd_l),
      .sync_q       (sync_l),
      .underrun_q   (underrun)
   );

   assign bclk  = raw ^ cfg_bclk_inv;
   assign fsync = sync_l ^ cfg_sync_actlow;
   assign sdata = sd_l;

endmodule

// File: rtl/sat_tx_chk.sv
module sat_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic cfg_bclk_inv,
   input logic cfg_sync_actlow,
   input logic bclk,
   input logic fsync,
   input logic sdata,
   input logic active,
   input logic underrun
);

   // R2
   drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdata) |-> (bclk == cfg_bclk_inv));

   // R1
   idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (!sdata && (fsync == cfg_sync_actlow)));

   // R9
   underrun_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> active);

   // R9
   underrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> !underrun);

   // R10
   stop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> !$past(tx_en));

endmodule

bind sat_tx sat_tx_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .tx_en          (tx_en),
   .cfg_bclk_inv   (cfg_bclk_inv),
   .cfg_sync_actlow(cfg_sync_actlow),
   .bclk           (bclk),
   .fsync          (fsync),
   .sdata          (sdata),
   .active         (active),
   .underrun       (underrun)
);

// File: tb/tb_sat_tx.sv
module tb_sat_tx;
   localparam int MAX_W = 32;
   localparam int DEPTH = 4;
   localparam int DIV_W = 8;
   localparam int WW    = $clog2(MAX_W + 1);

   logic             clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0;
   logic             cfg_early = 0, cfg_word_sync = 0, cfg_sync_actlow = 0;
   logic             cfg_bclk_inv = 0, cfg_two_slots = 0, cfg_lsb_first = 0;
   logic [WW-1:0]    cfg_word_w = WW'(8);
   logic [1:0]       cfg_slot_mask = 2'b00;
   logic [DIV_W-1:0] cfg_div = '0;
   logic             in_valid = 1'b0, in_ready;
   logic [MAX_W-1:0] in_data = '0;
   logic             bclk, fsync, sdata, active, underrun;

   sat_tx #(.MAX_W(MAX_W), .FIFO_DEPTH(DEPTH), .DIV_W(DIV_W)) dut (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
      .cfg_early(cfg_early), .cfg_word_sync(cfg_word_sync),
      .cfg_sync_actlow(cfg_sync_actlow), .cfg_bclk_inv(cfg_bclk_inv),
      .cfg_word_w(cfg_word_w), .cfg_two_slots(cfg_two_slots),
      .cfg_lsb_first(cfg_lsb_first), .cfg_slot_mask(cfg_slot_mask),
      .cfg_div(cfg_div), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .bclk(bclk), .fsync(fsync), .sdata(sdata),
      .active(active), .underrun(underrun)
   );

   always #2 clk = ~clk;

   int      nchk = 0, nbad = 0, ur_cnt = 0;
   bit      done = 0;
   longint  cyc = 0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (underrun) ur_cnt <= ur_cnt + 1;
   end

   logic [127:0]     cap_d, cap_s, exp_d, exp_s;
   int               cap_n, exp_n;
   longint           edge_t [2];
   logic [MAX_W-1:0] wq [8];
   int               wn;

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic cfg_set(input int w, input bit two, input bit early, input bit wsync,
                          input bit actlow, input bit inv, input bit lsb,
                          input logic [1:0] mask, input int div);
      @(negedge clk);
      cfg_word_w = WW'(w); cfg_two_slots = two; cfg_early = early;
      cfg_word_sync = wsync; cfg_sync_actlow = actlow; cfg_bclk_inv = inv;
      cfg_lsb_first = lsb; cfg_slot_mask = mask; cfg_div = DIV_W'(div);
      wn = 0;
   endtask

   task automatic push(input logic [MAX_W-1:0] w);
      @(negedge clk);
      in_data = w; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      wq[wn] = w; wn++;
   endtask

   // Record data and logical sync at each sampling edge of the bit clock.
   task automatic capture(input int n);
      logic prev, cur;
      cap_d = '0; cap_s = '0; cap_n = 0;
      prev = bclk;
      while (cap_n < n) begin
         @(negedge clk);
         cur = bclk;
         if (cur != prev && cur == ~cfg_bclk_inv) begin
            cap_d[cap_n] = sdata;
            cap_s[cap_n] = fsync ^ cfg_sync_actlow;
            if (cap_n < 2) edge_t[cap_n] = cyc;
            cap_n++;
         end
         prev = cur;
      end
   endtask

   // Expected stream from the requirements.
   task automatic build(input int nframes);
      int w, ns, f_len, ptr, p;
      bit live, s_l;
      logic [MAX_W-1:0] word;
      w = int'(cfg_word_w); ns = cfg_two_slots ? 2 : 1; f_len = ns * w;
      ptr = 0; exp_n = 0; exp_d = '0; exp_s = '0;
      if (cfg_early) begin
         exp_s[0] = 1'b1; exp_n = 1;
      end
      for (int f = 0; f < nframes; f++) begin
         for (int s = 0; s < ns; s++) begin
            live = !cfg_slot_mask[s];
            word = '0;
            if (live && ptr < wn) begin word = wq[ptr]; ptr++; end
            for (int b = 0; b < w; b++) begin
               p = s * w + b;
               if (cfg_word_sync)
                  s_l = cfg_early ? ((p < w - 1) || (p == f_len - 1)) : (p < w);
               else
                  s_l = cfg_early ? (p == f_len - 1) : (p == 0);
               exp_d[exp_n] = live ? word[cfg_lsb_first ? b : w - 1 - b] : 1'b0;
               exp_s[exp_n] = s_l;
               exp_n++;
            end
         end
      end
   endtask

   task automatic wait_idle();
      while (active) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic play(input string tag, input int nframes);
      build(nframes);
      @(negedge clk);
      tx_en = 1'b1;
      capture(exp_n);
      tx_en = 1'b0;
      wait_idle();
      chk({tag, " data"}, cap_d, exp_d);
      chk({tag, " sync"}, cap_s, exp_s);
   endtask

   task automatic t_reset();
      chk("R1 active", active, 0);
      chk("R1 sdata", sdata, 0);
      chk("R1 in_ready", in_ready, 1);
      chk("R1 bclk", bclk, 0);
      chk("R1 fsync", fsync, 0);
   endtask

   task automatic t_i2s();
      cfg_set(8, 1, 1, 1, 1, 0, 0, 2'b00, 2);
      push(32'hA5); push(32'h3C); push(32'hF0); push(32'h81);
      play("R3 R4 R6 R7 i2s", 2);
      chk("R7 idle fsync high", fsync, 1);
   endtask

   task automatic t_leftj();
      cfg_set(6, 1, 0, 1, 0, 1, 1, 2'b00, 2);
      push(32'h15); push(32'h2A); push(32'h07); push(32'h30);
      play("R2 R3 R5 leftj", 2);
      chk("R2 idle bclk inverted", bclk, 1);
   endtask

   task automatic t_dsp_early();
      cfg_set(5, 1, 1, 0, 0, 0, 0, 2'b00, 1);
      push(32'h16); push(32'h09);
      play("R5 R6 dsp early", 1);
   endtask

   task automatic t_dsp_late();
      cfg_set(7, 0, 0, 0, 0, 0, 0, 2'b00, 3);
      push(32'h55); push(32'h2B); push(32'h7F);
      play("R4 R5 dsp mono", 3);
      chk("R2 bit period", edge_t[1] - edge_t[0], 8);
   endtask

   task automatic t_mask();
      int u0;
      cfg_set(4, 1, 0, 1, 0, 0, 0, 2'b10, 1);
      push(32'h9); push(32'h6);
      u0 = ur_cnt;
      play("R8 mask slot1", 2);
      chk("R8 no starvation", ur_cnt - u0, 0);
      cfg_set(4, 0, 0, 1, 0, 0, 0, 2'b10, 1);
      push(32'hC);
      play("R8 mono ignores bit1", 1);
   endtask

   task automatic t_underrun();
      int u0;
      cfg_set(4, 0, 0, 0, 0, 0, 0, 2'b00, 1);
      u0 = ur_cnt;
      play("R9 empty fifo", 1);
      chk("R9 one pulse", ur_cnt - u0, 1);
   endtask

   task automatic t_disable();
      int extra;
      logic prev, cur;
      cfg_set(4, 1, 0, 1, 0, 0, 0, 2'b00, 2);
      push(32'h3); push(32'hE);
      @(negedge clk);
      tx_en = 1'b1;
      capture(3);
      tx_en = 1'b0;
      chk("R10 still active", active, 1);
      extra = 0;
      prev = bclk;
      while (active) begin
         @(negedge clk);
         cur = bclk;
         if (cur != prev && cur == 1'b1) extra++;
         prev = cur;
      end
      chk("R10 bits after clear", extra, 5);
      @(negedge clk);
      chk("R10 idle sdata", sdata, 0);
   endtask

   task automatic t_fifo();
      cfg_set(8, 0, 0, 1, 0, 0, 0, 2'b00, 1);
      for (int i = 0; i < DEPTH; i++) push(MAX_W'(8'h11 * (i + 1)));
      chk("R11 full not ready", in_ready, 0);
      @(negedge clk);
      in_data = 32'hEE; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      play("R11 order", DEPTH);
      chk("R11 ready after drain", in_ready, 1);
      wn = 0;
      play("R11 refused word absent", 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin
      do_reset();
      t_reset();
      t_i2s();
      t_leftj();
      t_dsp_early();
      t_dsp_late();
      t_mask();
      t_underrun();
      t_disable();
      t_fifo();
      done = 1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

endmodule